// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to 32 external interrupt pins. It gives each pin its own interrupt line toward a downstream interrupt distributor. Every pin input first passes through a two-flop synchroniser. A per-pin sense code then decides what counts as an event: a low level, a high level, a falling edge, a rising edge or either edge. Edges are found by comparing the current synchronised sample with the one from the cycle before.

Events are latched in a detect register, which software clears by writing 1 to a bit. A pin's pending request is its detect bit ANDed with its enable bit. Software changes enables only through two registers: writing 1 to a bit of one register sets that enable, and writing 1 to a bit of the other clears it. Each output line is a registered copy of its pin's pending bit.

Software reaches everything through a 32-bit register port. The port has a write strobe, a byte address and combinational read data.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset all enables, all detect bits and all pin configurations are zero, every read returns zero and every irq_o line is low.
- R2: A pin input reaches the detection logic through two synchronising flops. A level event applied just after rising edge k is readable in the detect register after edge k+3, and the matching irq_o line rises after edge k+4 if the pin is enabled.
- R3: A write to offset 0x08 sets the enable of every pin whose data bit is 1. Pins whose data bit is 0 keep their enable.
- R4: A write to offset 0x04 clears the enable of every pin whose data bit is 1. Reading offset 0x04 returns the enable mask, with bit n standing for pin n.
- R5: Offset 0x100 reads the detect register, bit n for pin n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: Pin n has a configuration register at offset 0x180 + 4*n. Only bits 5:0 are stored, and reads return them with the upper bits zero.
- R7: Sense code 0x01 detects a low level and 0x02 detects a high level. While the level stays active, the detect bit is set on every clock.
- R8: Sense code 0x04 detects a falling edge, 0x08 a rising edge and 0x0C either edge. Each edge is found by comparing two consecutive synchronised samples.
- R9: When an event and a write-1-to-clear of the same detect bit happen in the same cycle, the bit stays set.
- R10: Offset 0x00 reads detect AND enable. Each irq_o bit equals that pending bit one clock later.
- R11: A sense code of zero or any code other than the five defined ones never sets the detect bit.
- R12: Pins are independent. An event, configuration or enable on one pin never changes another pin's detect bit or irq_o line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_o | output | NUM_PINS | One interrupt line per pin |

## Verification
The hardest case to reach is a write-1-to-clear that lands on the same clock edge as a fresh event on that bit. The case needs an active level, or an edge timed through the synchroniser, to line up with the write cycle. The bench holds a level-sensed pin active and clears it on chosen cycles. It also runs a long random phase that mixes pin toggles, clears, enable changes and sense codes, both defined and undefined. A cycle-accurate model in the bench checks every cycle, so coincidences of events and clears are compared whenever they happen.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [NUM_PINS-1:0] irq_o
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [ADDR_W-1:0] OFS_PEND = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_ENCL = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFS_ENST = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFS_DET  = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(12'h180);

  logic [NUM_PINS-1:0] sync1_q, sync2_q, prev_q;
  logic [NUM_PINS-1:0] en_q, det_q, hit, clr_mask;
  logic [NUM_PINS*6-1:0] cfg_flat;
  logic [NUM_PINS-1:0] wmask;
  logic                cfg_sel;
  logic [IDX_W-1:0]    cfg_idx;
  logic [ADDR_W-1:0]   cfg_off;

  function automatic logic sense_hit(input logic [5:0] code, input logic cur, input logic old);
    case (code)
      6'h01:   return ~cur;
      6'h02:   return cur;
      6'h04:   return ~cur & old;
      6'h08:   return cur & ~old;
      6'h0C:   return cur ^ old;
      default: return 1'b0;
    endcase
  endfunction

  assign wmask    = reg_wdata[NUM_PINS-1:0];
  assign cfg_off  = reg_addr - OFS_CFG;
  assign cfg_idx  = cfg_off[2 +: IDX_W];
  assign cfg_sel  = (reg_addr >= OFS_CFG) && (cfg_off[1:0] == 2'b00) &&
                    ((cfg_off >> 2) < ADDR_W'(NUM_PINS));
  assign clr_mask = (reg_wr && reg_addr == OFS_DET) ? wmask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [5:0] cfg_q;
    always_ff @(posedge clk) begin
      if (!rst_n) cfg_q <= '0;
      else if (reg_wr && cfg_sel && cfg_idx == IDX_W'(g)) cfg_q <= reg_wdata[5:0];
    end
    assign cfg_flat[g*6 +: 6] = cfg_q;
    assign hit[g] = sense_hit(cfg_q, sync2_q[g], prev_q[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      det_q <= '0;
      irq_o <= '0;
    end else begin
      if (reg_wr && reg_addr == OFS_ENST) en_q <= en_q | wmask;
      else if (reg_wr && reg_addr == OFS_ENCL) en_q <= en_q & ~wmask;
      det_q <= (det_q & ~clr_mask) | hit;
      irq_o <= det_q & en_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_PEND)      reg_rdata = 32'(det_q & en_q);
    else if (reg_addr == OFS_ENCL) reg_rdata = 32'(en_q);
    else if (reg_addr == OFS_DET)  reg_rdata = 32'(det_q);
    else if (cfg_sel)              reg_rdata = 32'(cfg_flat[cfg_idx*6 +: 6]);
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_ENST) |=> ((en_q & $past(wmask)) == $past(wmask))); // R3
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_ENCL) |=> ((en_q & $past(wmask)) == '0)); // R4
  AST_DET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == OFS_DET) |=> ((det_q & $past(det_q)) == $past(det_q))); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_DET) |=> ((det_q & $past(hit)) == $past(hit))); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~$past(en_q)) == '0)); // R10
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb_top;
  localparam int N = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pin_i = '0;
  logic reg_wr = 1'b0;
  logic [8:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] irq_o;
  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;

  ext_irq_ctrl #(.NUM_PINS(N), .ADDR_W(9)) dut_i (.*);

  always #4 clk = ~clk;

  logic [N-1:0] m_s1, m_s2, m_prev, m_en, m_det, m_irq;
  logic [5:0] m_cfg [N];

  function automatic logic m_hit(input logic [5:0] c, input logic cur, input logic old);
    if (c == 6'h01) return !cur;
    if (c == 6'h02) return cur;
    if (c == 6'h04) return !cur && old;
    if (c == 6'h08) return cur && !old;
    if (c == 6'h0C) return cur != old;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] set, clr;
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_en <= '0; m_det <= '0; m_irq <= '0;
      for (int i = 0; i < N; i++) m_cfg[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) set[i] = m_hit(m_cfg[i], m_s2[i], m_prev[i]);
      clr = (reg_wr && reg_addr == 9'h100) ? reg_wdata : '0;
      m_det <= (m_det & ~clr) | set;
      m_irq <= m_det & m_en;
      m_s1 <= pin_i; m_s2 <= m_s1; m_prev <= m_s2;
      if (reg_wr && reg_addr == 9'h008) m_en <= m_en | reg_wdata;
      if (reg_wr && reg_addr == 9'h004) m_en <= m_en & ~reg_wdata;
      if (reg_wr && reg_addr >= 9'h180 && reg_addr[1:0] == 2'b00)
        m_cfg[(reg_addr - 9'h180) >> 2] <= reg_wdata[5:0];
    end
  end

  function automatic logic [31:0] m_read(input logic [8:0] a);
    if (a == 9'h000) return m_det & m_en;
    if (a == 9'h004) return m_en;
    if (a == 9'h100) return m_det;
    if (a >= 9'h180 && a[1:0] == 2'b00) return 32'(m_cfg[(a - 9'h180) >> 2]);
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    check("R10 R12 irq_o", irq_o, m_irq);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input string tag, input logic [8:0] a);
    reg_addr = a; #1;
    check(tag, reg_rdata, m_read(a));
  endtask

  task automatic rd_lit(input string tag, input logic [8:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; rst_n = 1'b1;
    // R1 reset state
    rd_lit("R1 pend", 9'h000, 0); rd_lit("R1 en", 9'h004, 0);
    rd_lit("R1 det", 9'h100, 0); rd_lit("R1 cfg7", 9'h19C, 0);
    check("R1 irq_o", irq_o, 0);
    // R6 configuration storage
    wr(9'h18C, 32'hFFFF_FFFF);
    rd_lit("R6 cfg3 masked", 9'h18C, 32'h3F);
    wr(9'h18C, 32'h0);
    // R2 latency through synchroniser, high level on pin 0
    wr(9'h180, 32'h02);
    wr(9'h008, 32'h1);
    pin_i[0] = 1'b1;
    tick(); tick(); rd_lit("R2 det not yet", 9'h100, 0);
    tick(); rd_lit("R2 det after 3", 9'h100, 1);
    check("R2 irq not yet", irq_o, 0);
    tick(); check("R2 irq after 4", irq_o, 1);
    // R9 clear while level active
    wr(9'h100, 32'h1); rd_lit("R9 set wins", 9'h100, 1);
    // R7 level released, clear then stays clear
    pin_i[0] = 1'b0; tick(); tick(); tick();
    wr(9'h100, 32'h1); rd_lit("R7 cleared", 9'h100, 0);
    tick(); rd_lit("R7 stays clear", 9'h100, 0);
    // R7 low level on pin 8
    wr(9'h1A0, 32'h01); tick(); tick();
    rd("R7 low level", 9'h100);
    check("R7 low level bit", reg_rdata[8], 1'b1);
    wr(9'h1A0, 32'h0); wr(9'h100, 32'hFFFF_FFFF);
    // R8 edges
    wr(9'h184, 32'h08); wr(9'h188, 32'h04); wr(9'h190, 32'h0C);
    pin_i[2] = 1'b1; pin_i[4] = 1'b1;
    repeat (4) tick();
    wr(9'h100, 32'hFFFF_FFFF);
    pin_i[1] = 1'b1; repeat (4) tick();
    rd_lit("R8 rise pin1", 9'h100, 32'h2);
    pin_i[2] = 1'b0; repeat (4) tick();
    rd_lit("R8 fall pin2", 9'h100, 32'h6);
    pin_i[4] = 1'b0; repeat (4) tick();
    rd_lit("R8 both pin4 falling", 9'h100, 32'h16);
    wr(9'h100, 32'h10);
    pin_i[4] = 1'b1; repeat (4) tick();
    rd_lit("R8 both pin4 rising", 9'h100, 32'h16);
    wr(9'h100, 32'hFFFF_FFFF);
    // R11 undefined codes
    wr(9'h194, 32'h03); wr(9'h198, 32'h10);
    pin_i[5] = 1'b1; pin_i[6] = 1'b1; repeat (4) tick();
    pin_i[5] = 1'b0; pin_i[6] = 1'b0; repeat (4) tick();
    rd_lit("R11 no detect", 9'h100, 0);
    // R3 / R4 enables, R10 pending
    wr(9'h008, 32'h0000_00F0); rd_lit("R3 set", 9'h004, 32'h0000_00F1);
    wr(9'h008, 32'h0); rd_lit("R3 zeros no effect", 9'h004, 32'h0000_00F1);
    wr(9'h004, 32'h0000_0030); rd_lit("R4 clear", 9'h004, 32'h0000_00C1);
    wr(9'h1A4, 32'h02); wr(9'h1A8, 32'h02);
    pin_i[9] = 1'b1; pin_i[10] = 1'b1; wr(9'h008, 32'h200);
    repeat (4) tick();
    rd("R10 pending", 9'h000);
    check("R12 irq only pin9", irq_o, 32'h200);
    // R5 partial clear
    pin_i[9] = 1'b0; pin_i[10] = 1'b0; repeat (3) tick();
    wr(9'h100, 32'h200); rd_lit("R5 partial w1c", 9'h100, 32'h400);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      int r;
      pin_i = pin_i ^ ($urandom() & $urandom() & $urandom());
      r = $urandom_range(0, 9);
      if (r == 0) wr(9'h008, $urandom());
      else if (r == 1) wr(9'h004, $urandom());
      else if (r == 2) wr(9'h100, $urandom());
      else if (r == 3) begin
        logic [5:0] codes [8] = '{6'h01, 6'h02, 6'h04, 6'h08, 6'h0C, 6'h00, 6'h05, 6'h3F};
        wr(9'h180 + 9'($urandom_range(0, N-1) * 4), 32'(codes[$urandom_range(0, 7)]));
      end else tick();
      rd("R5 R10 random read", (k % 3 == 0) ? 9'h100 : (k % 3 == 1) ? 9'h000 : 9'h004);
    end
    done = 1;
    finish_run();
  end
endmodule